// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port (Master or Slave)

This block moves one 8-bit word at a time over a four-wire synchronous serial link. It sends and receives in the same transfer. A bit in the configuration register makes it the clock-driving master or a clocked slave. Clock idle level, clock phase and bit order can all be set. Each pin has its own output enable, so the pads can be shared with general-purpose use.

In master mode a byte is started by writing the data register. A divider sets the serial clock half period to `baud + 1` system clocks. The select pin can work in three ways, chosen by the configuration bits:
- left to general-purpose use;
- watched as a mode-fault input;
- driven by the block as an automatic select output.

In slave mode the select pin is always the select input. The external clock, data-in and select are brought into the system clock domain through two-stage synchronisers. A completed byte sets a done flag and latches the received data. A single request line reports done or mode fault when requests are enabled.

Register map (3-bit address, 8-bit data):
- 0 CFG: [7] enable, [6] request enable, [5] master, [4] clock idle-high, [3] clock phase, [2] LSB first, [1] automatic select output, [0] reads 0.
- 1 CFG2: [0] fault enable, [7:1] read 0.
- 2 BAUD: the half-period value.
- 3 STAT: [7] done, [4] mode fault, other bits 0.
- 4 DATA: a write loads the transmit byte, a read returns the last received byte.

Top module: `spi_port`

## Requirements
- R1: With CFG[7]=1 and CFG[5]=1 the block drives `sclk_oe` and `mosi_oe` high. With CFG[5]=0, or after reset, both stay low. After reset every register reads 0 and every output enable is low.
- R2: While no transfer is running, `sclk_o` equals CFG[4]: low when CFG[4]=0, high when CFG[4]=1.
- R3: With CFG[3]=0, the first data bit is on the data output before the first clock edge, input is sampled on leading edges and output changes on trailing edges. With CFG[3]=1, output changes on leading edges and input is sampled on trailing edges.
- R4: CFG[2]=0 sends and receives bit 7 first. CFG[2]=1 sends and receives bit 0 first.
- R5: A master transfer has exactly 16 clock edges (8 cycles), spaced `BAUD+1` system clocks apart.
- R6: In master mode with CFG2[0]=0, `ss_oe` stays low and a low level on `ss_i` neither stops a transfer nor raises a fault.
- R7: In master mode with CFG2[0]=1 and CFG[1]=0, a low synchronised `ss_i` sets STAT[4], clears CFG[5] and drops `sclk_oe` and `mosi_oe`. STAT[4] clears on a CFG write that follows a STAT read which saw it set.
- R8: In master mode with CFG2[0]=1 and CFG[1]=1, `ss_oe` is high and `ss_o` is low from before the first clock edge until after the last one. `ss_o` is high while idle.
- R9: In slave mode `miso_oe` is high only while `ss_i` (synchronised) is low. While selected, 8 cycles of `sclk_i` exchange one byte.
- R10: CFG2 bits 7 to 1 always read 0, whatever was written to them.
- R11: At the end of each byte STAT[7] sets and DATA takes the received byte. STAT[7] clears on a DATA access that follows a STAT read which saw it set.
- R12: `irq` equals CFG[6] AND (STAT[7] OR STAT[4]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (for flag clearing) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Request line |
| sclk_i | input | 1 | Serial clock from pad (slave) |
| sclk_o | output | 1 | Serial clock to pad (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data from pad (slave) |
| mosi_o | output | 1 | Master-out data to pad |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Slave-out data from pad (master) |
| miso_o | output | 1 | Slave-out data to pad |
| miso_oe | output | 1 | Slave-out output enable |
| ss_i | input | 1 | Select from pad |
| ss_o | output | 1 | Select to pad |
| ss_oe | output | 1 | Select output enable |

## Verification
Master transfers are run with all four idle-level and phase settings. They mix both bit orders and three divider values, and use byte pairs whose bit patterns are not symmetric. A swapped edge role, a mirrored order or a miscounted half period therefore shows up as a wrong byte or a wrong edge spacing. Slave transfers are run under two opposite settings, so the slave's edge decoding is tried separately from the master's clock generator. The general-purpose select case holds `ss_i` low through a whole transfer. The fault case lowers it on an idle master, which separates "ignored" from "fault".

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_BAUD = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd4;

  typedef struct packed {
    logic en;
    logic irq_en;
    logic master;
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic ss_auto;
    logic fault_en;
  } spi_cfg_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic              fault_set,
  input  logic [DATA_W-1:0] rx_in,
  output spi_cfg_t          cfg,
  output logic [DIV_W-1:0]  half_div,
  output logic [DATA_W-1:0] tx_byte,
  output logic              start,
  output logic              done,
  output logic              fault
);

  spi_cfg_t          cfg_q, cfg_d;
  logic [DIV_W-1:0]  baud_q, baud_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              done_q, done_d;
  logic              done_arm_q, done_arm_d;
  logic              fault_q, fault_d;
  logic              fault_arm_q, fault_arm_d;

  logic wr_cfg, wr_cfg2, wr_baud, wr_data, stat_rd, data_acc;

  assign wr_cfg   = wr_en && (addr == A_CFG);
  assign wr_cfg2  = wr_en && (addr == A_CFG2);
  assign wr_baud  = wr_en && (addr == A_BAUD);
  assign wr_data  = wr_en && (addr == A_DATA);
  assign stat_rd  = rd_en && (addr == A_STAT);
  assign data_acc = (wr_en || rd_en) && (addr == A_DATA);

  assign start = wr_data && cfg_q.en && cfg_q.master && !busy;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_cfg) begin
      cfg_d.en        = wdata[7];
      cfg_d.irq_en    = wdata[6];
      cfg_d.master    = wdata[5];
      cfg_d.cpol      = wdata[4];
      cfg_d.cpha      = wdata[3];
      cfg_d.lsb_first = wdata[2];
      cfg_d.ss_auto   = wdata[1];
    end
    if (wr_cfg2) begin
      cfg_d.fault_en = wdata[0];
    end
    if (fault_set) begin
      cfg_d.master = 1'b0;
    end
  end

  always_comb begin
    baud_d = wr_baud ? wdata[DIV_W-1:0] : baud_q;
    tx_d   = (wr_data && !busy) ? wdata : tx_q;
    rx_d   = done_set ? rx_in : rx_q;
  end

  always_comb begin
    done_d     = done_q;
    done_arm_d = done_arm_q;
    if (stat_rd && done_q) begin
      done_arm_d = 1'b1;
    end
    if (data_acc && done_arm_q) begin
      done_d     = 1'b0;
      done_arm_d = 1'b0;
    end
    if (done_set) begin
      done_d     = 1'b1;
      done_arm_d = 1'b0;
    end
  end

  always_comb begin
    fault_d     = fault_q;
    fault_arm_d = fault_arm_q;
    if (stat_rd && fault_q) begin
      fault_arm_d = 1'b1;
    end
    if (wr_cfg && fault_arm_q) begin
      fault_d     = 1'b0;
      fault_arm_d = 1'b0;
    end
    if (fault_set) begin
      fault_d     = 1'b1;
      fault_arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      baud_q      <= '0;
      tx_q        <= '0;
      rx_q        <= '0;
      done_q      <= 1'b0;
      done_arm_q  <= 1'b0;
      fault_q     <= 1'b0;
      fault_arm_q <= 1'b0;
    end else begin
      cfg_q       <= cfg_d;
      baud_q      <= baud_d;
      tx_q        <= tx_d;
      rx_q        <= rx_d;
      done_q      <= done_d;
      done_arm_q  <= done_arm_d;
      fault_q     <= fault_d;
      fault_arm_q <= fault_arm_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG:  rdata[7:0] = {cfg_q.en, cfg_q.irq_en, cfg_q.master, cfg_q.cpol,
                            cfg_q.cpha, cfg_q.lsb_first, cfg_q.ss_auto, 1'b0};
      A_CFG2: rdata[7:0] = {7'b0, cfg_q.fault_en};
      A_BAUD: rdata[DIV_W-1:0] = baud_q;
      A_STAT: rdata[7:0] = {done_q, 2'b0, fault_q, 4'b0};
      A_DATA: rdata = rx_q;
      default: rdata = '0;
    endcase
  end

  assign cfg      = cfg_q;
  assign half_div = baud_q;
  assign tx_byte  = tx_q;
  assign done     = done_q;
  assign fault    = fault_q;

  // R11
  done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> rx_q == $past(rx_in));

  // R10
  cfg2_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CFG2) |-> rdata[7:1] == 7'b0);

  // R7
  fault_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> !cfg_q.master);

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned BITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIV_W-1:0] half_div,
  output logic             busy,
  output logic             sclk_act,
  output logic             edge_p,
  output logic             finish
);

  localparam int unsigned HCW = $clog2(2*BITS + 1);
  localparam logic [HCW-1:0] LAST_HC = HCW'(2*BITS);

  logic             busy_q, busy_d;
  logic             sclk_q, sclk_d;
  logic [HCW-1:0]   hc_q, hc_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick;

  assign tick   = busy_q && (div_q == half_div) && !abort;
  assign edge_p = tick && (hc_q != LAST_HC);
  assign finish = tick && (hc_q == LAST_HC);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    hc_d   = hc_q;
    div_d  = div_q;
    if (abort) begin
      busy_d = 1'b0;
      sclk_d = 1'b0;
      hc_d   = '0;
      div_d  = '0;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      hc_d   = '0;
      div_d  = '0;
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        if (finish) begin
          busy_d = 1'b0;
          hc_d   = '0;
        end else begin
          hc_d   = hc_q + HCW'(1);
          sclk_d = ~sclk_q;
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      hc_q   <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      hc_q   <= hc_d;
      div_q  <= div_d;
    end
  end

  assign busy     = busy_q;
  assign sclk_act = sclk_q;

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> !sclk_q);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned BITS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              edge_p,
  input  logic                              wrap,
  input  logic                              cpha,
  input  logic                              lsb_first,
  input  logic                              sdi,
  input  logic [BITS-1:0]                   tx_byte,
  output logic                              sdo,
  output logic [BITS-1:0]                   rx_now,
  output logic [$clog2(2*BITS+1)-1:0]       edge_cnt,
  output logic                              byte_done
);

  localparam int unsigned IW = $clog2(BITS);
  localparam int unsigned EW = $clog2(2*BITS + 1);
  localparam logic [EW-1:0] LAST_E = EW'(2*BITS - 1);
  localparam logic [IW-1:0] TOP_I  = IW'(BITS - 1);

  logic [EW-1:0]   ec_q, ec_d;
  logic [IW-1:0]   di_q, di_d;
  logic [IW-1:0]   sc_q, sc_d;
  logic [BITS-1:0] rx_q, rx_d;
  logic            lead, samp, is_last, adv;
  logic [IW-1:0]   tx_pos, rx_pos;

  assign lead    = ~ec_q[0];
  assign samp    = lead ^ cpha;
  assign is_last = (ec_q == LAST_E);
  assign adv     = !samp && (ec_q != '0) && !is_last;
  assign tx_pos  = lsb_first ? di_q : TOP_I - di_q;
  assign rx_pos  = lsb_first ? sc_q : TOP_I - sc_q;
  assign sdo     = tx_byte[tx_pos];

  always_comb begin
    ec_d = ec_q;
    di_d = di_q;
    sc_d = sc_q;
    rx_d = rx_q;
    if (clr) begin
      ec_d = '0;
      di_d = '0;
      sc_d = '0;
    end else if (edge_p) begin
      if (samp) begin
        rx_d[rx_pos] = sdi;
        sc_d = sc_q + IW'(1);
      end
      if (adv) begin
        di_d = di_q + IW'(1);
      end
      if (is_last && wrap) begin
        ec_d = '0;
        di_d = '0;
        sc_d = '0;
      end else begin
        ec_d = ec_q + EW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ec_q <= '0;
      di_q <= '0;
      sc_q <= '0;
      rx_q <= '0;
    end else begin
      ec_q <= ec_d;
      di_q <= di_d;
      sc_q <= sc_d;
      rx_q <= rx_d;
    end
  end

  assign rx_now    = rx_d;
  assign edge_cnt  = ec_q;
  assign byte_done = edge_p && !clr && is_last;

  // R3
  sample_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && !clr && is_last) |-> sc_q == (cpha ? TOP_I : IW'(0)));

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe
);

  localparam int unsigned EW = $clog2(2*DATA_W + 1);

  spi_cfg_t          cfg;
  logic [DIV_W-1:0]  half_div;
  logic [DATA_W-1:0] tx_byte, rx_now;
  logic              start, done, fault;
  logic              m_busy, m_sclk, m_edge, m_finish, m_abort;
  logic              sclk_s, ss_s, mosi_s, sclk_prev_q;
  logic              slave_sel, s_edge, s_done, m_fault;
  logic              sh_clr, sh_edge, sh_sdi, sh_sdo;
  logic [EW-1:0]     sh_cnt;
  logic              is_master;

  spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_i, ss_i, mosi_i}),
    .q     ({sclk_s, ss_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign is_master = cfg.en && cfg.master;
  assign slave_sel = cfg.en && !cfg.master && !ss_s;
  assign s_edge    = slave_sel && (sclk_s != sclk_prev_q);
  assign m_fault   = is_master && cfg.fault_en && !cfg.ss_auto && !ss_s;
  assign m_abort   = m_fault || !is_master;

  spi_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .busy      (m_busy),
    .done_set  (is_master ? m_finish : s_done),
    .fault_set (m_fault),
    .rx_in     (rx_now),
    .cfg       (cfg),
    .half_div  (half_div),
    .tx_byte   (tx_byte),
    .start     (start),
    .done      (done),
    .fault     (fault)
  );

  spi_clkgen #(.DIV_W(DIV_W), .BITS(DATA_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .abort    (m_abort),
    .half_div (half_div),
    .busy     (m_busy),
    .sclk_act (m_sclk),
    .edge_p   (m_edge),
    .finish   (m_finish)
  );

  assign sh_clr  = cfg.master ? start : !slave_sel;
  assign sh_edge = cfg.master ? m_edge : s_edge;
  assign sh_sdi  = cfg.master ? miso_i : mosi_s;

  spi_shifter #(.BITS(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sh_clr),
    .edge_p    (sh_edge),
    .wrap      (!cfg.master),
    .cpha      (cfg.cpha),
    .lsb_first (cfg.lsb_first),
    .sdi       (sh_sdi),
    .tx_byte   (tx_byte),
    .sdo       (sh_sdo),
    .rx_now    (rx_now),
    .edge_cnt  (sh_cnt),
    .byte_done (s_done)
  );

  assign sclk_o  = m_sclk ^ cfg.cpol;
  assign sclk_oe = is_master;
  assign mosi_o  = sh_sdo;
  assign mosi_oe = is_master;
  assign miso_o  = sh_sdo;
  assign miso_oe = slave_sel;
  assign ss_o    = !m_busy;
  assign ss_oe   = is_master && cfg.fault_en && cfg.ss_auto;
  assign irq     = cfg.irq_en && (done || fault);

  // R5
  edge_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_finish |-> sh_cnt == EW'(2*DATA_W));

  // R9
  miso_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!cfg.master && !ss_s));

  // R7
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!sclk_oe && !mosi_oe));

  // R8
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && m_edge) |-> (ss_o == 1'b0));

endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1;
  logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

  int nchk = 0;
  int nfail = 0;
  bit mdl_on = 1'b0;
  bit mdl_cpol = 1'b0;
  bit mdl_auto = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pick(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 500; i++) begin
      reg_rd(3'd3, s);
      if (s[7]) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // behavioural per-clock model of master idle/select pins
  always @(negedge clk) begin
    if (rst_n && mdl_on) begin
      if (ss_o) chk(sclk_o == mdl_cpol, "R2 idle clock level", sclk_o, mdl_cpol);
      if (mdl_auto) chk(ss_oe == 1'b1, "R8 select output enabled", ss_oe, 1);
    end
  end

  task automatic master_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                             input bit cpol, input bit cpha, input bit lsb,
                             input logic [7:0] baud, input bit fen, input bit auto_ss);
    logic [7:0] got, d;
    time t_first, t_last;
    bit ok;
    got = '0;
    t_first = 0;
    t_last = 0;
    reg_wr(3'd1, {7'b0, fen});
    reg_wr(3'd2, baud);
    reg_wr(3'd0, {3'b111, cpol, cpha, lsb, auto_ss, 1'b0});
    @(negedge clk);
    mdl_cpol = cpol;
    mdl_auto = fen && auto_ss;
    mdl_on = 1'b1;
    chk(sclk_oe && mosi_oe, "R1 master drives clock and data", {sclk_oe, mosi_oe}, 3);
    chk(ss_oe == (fen && auto_ss), "R6/R8 select enable", ss_oe, fen && auto_ss);
    miso_i = cpha ? 1'b0 : pick(stx, 0, lsb);
    fork
      reg_wr(3'd4, mtx);
      begin
        for (int k = 0; k < 8; k++) begin
          if (!cpha) begin
            @(sclk_o);
            if (k == 0) t_first = $time;
            if (fen && auto_ss) chk(ss_o == 1'b0, "R8 select low in transfer", ss_o, 0);
            got[lsb ? k : 7-k] = mosi_o;
            @(sclk_o);
            if (k < 7) miso_i = pick(stx, k+1, lsb);
          end else begin
            @(sclk_o);
            if (k == 0) t_first = $time;
            if (fen && auto_ss) chk(ss_o == 1'b0, "R8 select low in transfer", ss_o, 0);
            miso_i = pick(stx, k, lsb);
            @(sclk_o);
            got[lsb ? k : 7-k] = mosi_o;
          end
        end
        t_last = $time;
      end
    join
    chk((t_last - t_first) == 15 * (baud + 1) * CLK_PERIOD, "R5 edge spacing",
        int'(t_last - t_first), 15 * (baud + 1) * CLK_PERIOD);
    wait_done(ok);
    chk(ok, "R11 done flag set", ok, 1);
    chk(irq == 1'b1, "R12 request on done", irq, 1);
    chk(got == mtx, "R3/R4 master sent byte", got, mtx);
    reg_rd(3'd4, d);
    chk(d == stx, "R4/R11 master received byte", d, stx);
    reg_rd(3'd3, d);
    chk(d == 8'h00, "R6/R11 status after clear", d, 0);
    chk(irq == 1'b0, "R12 request cleared", irq, 0);
    chk(sclk_o == cpol, "R2 idle after transfer", sclk_o, cpol);
    if (fen && auto_ss) chk(ss_o == 1'b1, "R8 select high idle", ss_o, 1);
    mdl_on = 1'b0;
  endtask

  task automatic slave_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                            input bit cpol, input bit cpha, input bit lsb);
    logic [7:0] got, d;
    bit ok;
    got = '0;
    sclk_i = cpol;
    ss_i = 1'b1;
    reg_wr(3'd1, 8'h00);
    reg_wr(3'd0, {3'b100, cpol, cpha, lsb, 2'b00});
    reg_wr(3'd4, stx);
    repeat (4) @(negedge clk);
    chk(miso_oe == 1'b0, "R9 no drive while deselected", miso_oe, 0);
    chk(sclk_oe == 1'b0 && mosi_oe == 1'b0, "R1 slave releases clock/data", {sclk_oe, mosi_oe}, 0);
    ss_i = 1'b0;
    if (!cpha) mosi_i = pick(mtx, 0, lsb);
    repeat (8) @(negedge clk);
    chk(miso_oe == 1'b1, "R9 drive while selected", miso_oe, 1);
    for (int k = 0; k < 8; k++) begin
      if (!cpha) begin
        got[lsb ? k : 7-k] = miso_o;
        sclk_i = ~cpol;
        repeat (8) @(negedge clk);
        sclk_i = cpol;
        if (k < 7) mosi_i = pick(mtx, k+1, lsb);
        repeat (8) @(negedge clk);
      end else begin
        sclk_i = ~cpol;
        mosi_i = pick(mtx, k, lsb);
        repeat (8) @(negedge clk);
        got[lsb ? k : 7-k] = miso_o;
        sclk_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    ss_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(miso_oe == 1'b0, "R9 release after deselect", miso_oe, 0);
    wait_done(ok);
    chk(ok, "R11 slave done", ok, 1);
    chk(irq == 1'b0, "R12 request masked", irq, 0);
    chk(got == stx, "R3/R4 slave sent byte", got, stx);
    reg_rd(3'd4, d);
    chk(d == mtx, "R9/R11 slave received byte", d, mtx);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({sclk_oe, mosi_oe, miso_oe, ss_oe, irq} == 5'b0, "R1 reset enables", {sclk_oe, mosi_oe, miso_oe, ss_oe, irq}, 0);
    reg_rd(3'd0, d); chk(d == 8'h00, "R1 reset cfg", d, 0);
    reg_rd(3'd3, d); chk(d == 8'h00, "R1 reset status", d, 0);
    reg_rd(3'd4, d); chk(d == 8'h00, "R1 reset data", d, 0);

    // R10 reserved bits of CFG2
    reg_wr(3'd1, 8'hFF);
    reg_rd(3'd1, d); chk(d == 8'h01, "R10 cfg2 padding", d, 8'h01);
    reg_wr(3'd1, 8'hFE);
    reg_rd(3'd1, d); chk(d == 8'h00, "R10 cfg2 padding cleared", d, 0);

    // master transfers, automatic select output (R2 R3 R4 R5 R8 R11 R12)
    master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b1);
    master_xfer(8'hC3, 8'h96, 1'b1, 1'b0, 1'b1, 8'd0, 1'b1, 1'b1);
    master_xfer(8'h5A, 8'hE1, 1'b0, 1'b1, 1'b0, 8'd2, 1'b1, 1'b1);
    master_xfer(8'h81, 8'h7E, 1'b1, 1'b1, 1'b1, 8'd1, 1'b1, 1'b1);

    // R6 select as general-purpose pin: low ss_i ignored
    ss_i = 1'b0;
    master_xfer(8'h2D, 8'hB4, 1'b0, 1'b1, 1'b0, 8'd1, 1'b0, 1'b1);
    reg_rd(3'd0, d); chk(d[5] == 1'b1, "R6 master bit kept", d[5], 1);
    ss_i = 1'b1;
    reg_wr(3'd0, 8'h00);

    // R7 mode fault
    reg_wr(3'd1, 8'h01);
    reg_wr(3'd0, 8'hE0);
    repeat (4) @(negedge clk);
    chk(sclk_oe == 1'b1, "R7 master before fault", sclk_oe, 1);
    reg_rd(3'd3, d); chk(d == 8'h00, "R7 no fault while high", d, 0);
    ss_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(sclk_oe == 1'b0 && mosi_oe == 1'b0, "R7 drivers released", {sclk_oe, mosi_oe}, 0);
    chk(irq == 1'b1, "R12 request on fault", irq, 1);
    reg_rd(3'd3, d); chk(d == 8'h10, "R7 fault flag", d, 8'h10);
    reg_rd(3'd0, d); chk(d == 8'hC0, "R7 master bit cleared", d, 8'hC0);
    ss_i = 1'b1;
    repeat (4) @(negedge clk);
    reg_wr(3'd0, 8'h80);
    reg_rd(3'd3, d); chk(d == 8'h00, "R7 fault cleared", d, 0);
    chk(irq == 1'b0, "R12 request off", irq, 0);

    // R9 slave transfers
    slave_xfer(8'h6B, 8'hD2, 1'b0, 1'b0, 1'b0);
    slave_xfer(8'h1E, 8'hA7, 1'b1, 1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule